// File: doc/BRIEF.md
# Programmable master clock-enable generator

The block produces a master clock enable from one of four source tick inputs. All source ticks are single-cycle enables in the one reference clock domain. A control word picks the source and a prescaler code. The prescaler divides by a power of two, and its top code can optionally divide by three. The control word also holds a post-divider index into a four-entry table of ratios. The output `mck_en` is high for one reference cycle at the end of every period, and a period is N ticks of the selected source. N is the prescaler ratio multiplied by the table entry.

Software writes the control word through a plain write strobe and reads back the accepted word. It then polls `ready` until the new setting is in effect. A build-time layout parameter fixes where the prescaler field sits and which bits exist. A new setting is held as pending and goes live only when the current output period completes, so no period is ever shortened. An illegal setting is refused, and a sticky error flag records the refusal.

Top module: `mck_gen`

## Requirements
- R1: After reset the block uses source 0, prescaler code 0 and divider index 0. `ready` is 1, `err` is 0 and `ctrl_rdata` is 0.
- R2: Bits 1:0 of the control word select the source (0 to 3). Only ticks of the selected source advance the period count, and `mck_en` pulses once every N such ticks.
- R3: The prescaler field is 3 bits wide. Its lowest bit is bit 2 when LAYOUT=0 and bit 4 when LAYOUT=1. A code p from 0 to 6 multiplies N by 2^p.
- R4: Prescaler code 7 multiplies N by 3 when DIV3_EN=1. When DIV3_EN=0, code 7 is an invalid setting.
- R5: Bits 9:8 index the divider table DIV_TABLE, and N is multiplied by the selected entry. An entry of 0 makes that index an invalid setting.
- R6: A write of an invalid setting made while `ready` is 1 sets `err`, and `err` stays set until reset. Such a write changes neither the active setting nor `ctrl_rdata`, and `ready` stays 1.
- R7: `ctrl_rdata` returns the last accepted word ANDed with the layout mask. The mask is 0x31F for LAYOUT=0 and 0x373 for LAYOUT=1.
- R8: In the cycle after a valid write is accepted, `ready` is 0.
- R9: A write while `ready` is 0 is ignored. It does not change `ctrl_rdata`, it does not set `err`, and it does not affect any later period.
- R10: A pending setting takes effect only when the current period ends. The final period of the old setting is full length. `ready` returns to 1 in the same cycle as that period's `mck_en` pulse, and the next period uses the new source and N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One-cycle tick per source clock |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | W | Control word to write |
| ctrl_rdata | output | W | Accepted control word, masked by layout |
| ready | output | 1 | Last accepted setting is in effect |
| err | output | 1 | Sticky invalid-setting flag |
| mck_en | output | 1 | Master clock enable pulse |

## Verification
The four sources tick at four different rates: every cycle, every second, every third and every fourth cycle. A wrong source choice therefore shows up as a wrong count of selected-source ticks per period. The settings cover codes that give an exact power of two, the divide-by-three code, each nonzero table entry and the zero entry. Each of these yields a different N, so a misplaced field or a wrong ratio changes the measured interval. A second instance with the other layout and no divide-by-three option gets a word whose prescaler bits decode differently under the two layouts, together with an illegal code 7. A write during a long pending period, and a switch from a 256-tick period, check that reconfiguration waits for the period boundary and that writes made while busy are dropped.

// File: rtl/mck_pkg.sv
package mck_pkg;

  localparam int SRC_N = 4;
  localparam int SEL_W = 2;
  localparam int PRES_W = 3;
  localparam int DIDX_LSB = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_PEND = 1'b1} mck_state_e;

  function automatic int pres_lsb(input int layout);
    return (layout == 0) ? 2 : 4;
  endfunction

  function automatic logic [15:0] layout_mask(input int layout);
    return (layout == 0) ? 16'h031F : 16'h0373;
  endfunction

endpackage

// File: rtl/mck_decode.sv
module mck_decode
  import mck_pkg::*;
#(
  parameter int W = 16,
  parameter int CNT_W = 16,
  parameter int LAYOUT = 0,
  parameter bit DIV3_EN = 1'b1,
  parameter logic [3:0][7:0] DIV_TABLE = {8'd0, 8'd4, 8'd2, 8'd1}
) (
  input  logic [W-1:0]     word,
  output logic [SEL_W-1:0] src,
  output logic [CNT_W-1:0] lim,
  output logic             valid,
  output logic [W-1:0]     masked
);

  localparam int PL = pres_lsb(LAYOUT);
  localparam logic [W-1:0] MASK = W'(layout_mask(LAYOUT));

  logic [PRES_W-1:0] pres;
  logic [1:0]        didx;
  logic [6:0]        ratio;
  logic              pres_ok;
  logic [7:0]        dv;
  logic [14:0]       prod;

  assign pres   = word[PL +: PRES_W];
  assign didx   = word[DIDX_LSB +: 2];
  assign src    = word[SEL_W-1:0];
  assign masked = word & MASK;
  assign dv     = DIV_TABLE[didx];

  generate
    if (DIV3_EN) begin : g_div3
      always_comb begin
        pres_ok = 1'b1;
        if (pres == 3'd7) ratio = 7'd3;
        else              ratio = 7'd1 << pres;
      end
    end else begin : g_nodiv3
      always_comb begin
        pres_ok = (pres != 3'd7);
        ratio   = 7'd1 << pres;
      end
    end
  endgenerate

  assign prod  = {8'd0, ratio} * {7'd0, dv};
  assign lim   = CNT_W'(prod - 15'd1);
  assign valid = pres_ok && (dv != 8'd0);

endmodule

// File: rtl/mck_ctrl.sv
module mck_ctrl
  import mck_pkg::*;
#(
  parameter int W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             dec_valid,
  input  logic [SEL_W-1:0] dec_src,
  input  logic [CNT_W-1:0] dec_lim,
  input  logic [W-1:0]     dec_masked,
  input  logic             swap,
  output logic             ready,
  output logic             err,
  output logic [W-1:0]     rdata,
  output logic             pend_vld,
  output logic [SEL_W-1:0] pend_src,
  output logic [CNT_W-1:0] pend_lim
);

  mck_state_e state;

  assign pend_vld = (state == ST_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ready    <= 1'b1;
      err      <= 1'b0;
      rdata    <= '0;
      pend_src <= '0;
      pend_lim <= '0;
    end else begin
      if (state == ST_PEND && swap) begin
        state <= ST_IDLE;
        ready <= 1'b1;
      end
      if (state == ST_IDLE && wr_en) begin
        if (dec_valid) begin
          state    <= ST_PEND;
          ready    <= 1'b0;
          rdata    <= dec_masked;
          pend_src <= dec_src;
          pend_lim <= dec_lim;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R8: an accepted write drops ready on the next cycle
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ready && dec_valid) |=> !ready);

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/mck_divider.sv
module mck_divider
  import mck_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_LIM = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             pend_vld,
  input  logic [SEL_W-1:0] pend_src,
  input  logic [CNT_W-1:0] pend_lim,
  output logic             swap,
  output logic             mck_en
);

  logic [SEL_W-1:0] act_src;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             last;

  assign tick = src_tick[act_src];
  assign last = tick && (cnt == lim);
  assign swap = last && pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src <= '0;
      lim     <= RST_LIM;
      cnt     <= '0;
      mck_en  <= 1'b0;
    end else begin
      mck_en <= last;
      if (tick) cnt <= last ? '0 : cnt + 1'b1;
      if (swap) begin
        act_src <= pend_src;
        lim     <= pend_lim;
      end
    end
  end

  // R2: the period counter never runs past its limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

  // R10: the limit only changes when a period has just ended
  a_r10_switch_at_end: assert property (@(posedge clk) disable iff (rst)
    (lim != $past(lim)) |-> (cnt == '0 && mck_en));

endmodule

// File: rtl/mck_gen.sv
module mck_gen
  import mck_pkg::*;
#(
  parameter int W = 16,
  parameter int CNT_W = 16,
  parameter int LAYOUT = 0,
  parameter bit DIV3_EN = 1'b1,
  parameter logic [3:0][7:0] DIV_TABLE = {8'd0, 8'd4, 8'd2, 8'd1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       src_tick,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     ctrl_rdata,
  output logic             ready,
  output logic             err,
  output logic             mck_en
);

  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(DIV_TABLE[0]) - 1'b1;

  logic [SEL_W-1:0] dec_src;
  logic [CNT_W-1:0] dec_lim;
  logic             dec_valid;
  logic [W-1:0]     dec_masked;
  logic             swap;
  logic             pend_vld;
  logic [SEL_W-1:0] pend_src;
  logic [CNT_W-1:0] pend_lim;

  mck_decode #(
    .W(W), .CNT_W(CNT_W), .LAYOUT(LAYOUT),
    .DIV3_EN(DIV3_EN), .DIV_TABLE(DIV_TABLE)
  ) u_dec (
    .word(wr_data), .src(dec_src), .lim(dec_lim),
    .valid(dec_valid), .masked(dec_masked)
  );

  mck_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .dec_valid(dec_valid), .dec_src(dec_src), .dec_lim(dec_lim),
    .dec_masked(dec_masked), .swap(swap),
    .ready(ready), .err(err), .rdata(ctrl_rdata),
    .pend_vld(pend_vld), .pend_src(pend_src), .pend_lim(pend_lim)
  );

  mck_divider #(.CNT_W(CNT_W), .RST_LIM(RST_LIM)) u_div (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .pend_vld(pend_vld), .pend_src(pend_src), .pend_lim(pend_lim),
    .swap(swap), .mck_en(mck_en)
  );

  // R10: ready comes back together with the last pulse of the old setting
  a_r10_ready_with_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> mck_en);

  // R9: writes while busy leave readback and error untouched
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!ready && wr_en) |=> ($stable(ctrl_rdata) && $stable(err)));

endmodule

// File: tb/tb_mck_gen.sv
module tb_mck_gen;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] src_tick;
  int unsigned cyc = 0;

  logic         wr_en = 1'b0, wr_en_b = 1'b0;
  logic [W-1:0] wr_data = '0, wr_data_b = '0;
  logic [W-1:0] ctrl_rdata, ctrl_rdata_b;
  logic         ready, ready_b, err, err_b, mck_en, mck_en_b;

  int checks = 0;
  int errors = 0;
  int pulse_checks = 0;

  int q_src[$];
  int q_n[$];
  int exp_src = 0;
  int exp_n = 1;
  int mon_cnt = 0;
  logic prev_ready = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  for (genvar k = 0; k < 4; k++) begin : g_tick
    assign src_tick[k] = ((cyc % (k + 1)) == 0);
  end

  mck_gen #(.LAYOUT(0), .DIV3_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_rdata(ctrl_rdata),
    .ready(ready), .err(err), .mck_en(mck_en)
  );

  mck_gen #(.LAYOUT(1), .DIV3_EN(1'b0)) dut_b (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .wr_en(wr_en_b), .wr_data(wr_data_b), .ctrl_rdata(ctrl_rdata_b),
    .ready(ready_b), .err(err_b), .mck_en(mck_en_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_cfg(input int s, input int n);
    q_src.push_back(s);
    q_n.push_back(n);
  endtask

  task automatic write_a(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic write_b(input logic [W-1:0] v);
    @(negedge clk); wr_en_b = 1'b1; wr_data_b = v;
    @(negedge clk); wr_en_b = 1'b0;
  endtask

  task automatic wait_ready_a;
    while (!ready) @(negedge clk);
  endtask

  // scoreboard monitor: checks every period of dut against the expected N
  always @(negedge clk) begin
    if (rst) begin
      mon_cnt = 0;
      prev_ready = 1'b1;
    end else begin
      if (mck_en) begin
        check(mon_cnt == exp_n, "R2 R3 R4 R5 period ticks", mon_cnt, exp_n);
        pulse_checks++;
        mon_cnt = 0;
      end
      if (ready && !prev_ready) begin
        check(mck_en, "R10 ready rise with pulse", int'(mck_en), 1);
        if (q_n.size() == 0) begin
          check(1'b0, "R10 unexpected switch", 0, 1);
        end else begin
          exp_src = q_src.pop_front();
          exp_n = q_n.pop_front();
        end
      end
      prev_ready = ready;
      if (src_tick[exp_src]) mon_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(ready == 1'b1, "R1 ready", int'(ready), 1);
    check(err == 1'b0, "R1 err", int'(err), 0);
    check(ctrl_rdata == 16'h0, "R1 rdata", int'(ctrl_rdata), 0);
    check(ready_b == 1'b1 && err_b == 1'b0, "R1 second instance", int'(ready_b), 1);
    repeat (10) @(negedge clk);

    // src1, prescale /2, div /1 -> N=2
    push_cfg(1, 2);
    write_a(16'h0005);
    check(ready == 1'b0, "R8 ready low after write", int'(ready), 0);
    check(ctrl_rdata == 16'h0005, "R7 rdata 0x005", int'(ctrl_rdata), 16'h5);
    wait_ready_a();
    repeat (20) @(negedge clk);

    // src3, prescale /64, div /4 -> N=256
    push_cfg(3, 256);
    write_a(16'h021B);
    wait_ready_a();

    // src2, code 7 (/3), div /2 -> N=6; pends behind a long period
    push_cfg(2, 6);
    write_a(16'h011E);
    check(ready == 1'b0, "R10 pending behind long period", int'(ready), 0);
    repeat (5) @(negedge clk);
    write_a(16'h0001);
    check(ctrl_rdata == 16'h011E, "R9 busy write rdata", int'(ctrl_rdata), 16'h11E);
    check(err == 1'b0, "R9 busy write err", int'(err), 0);
    check(ready == 1'b0, "R9 still pending", int'(ready), 0);
    wait_ready_a();
    repeat (40) @(negedge clk);

    // divider index 3 has a zero entry -> invalid
    write_a(16'h0300);
    check(err == 1'b1, "R5 R6 zero entry sets err", int'(err), 1);
    check(ready == 1'b1, "R6 ready stays high", int'(ready), 1);
    check(ctrl_rdata == 16'h011E, "R6 rdata unchanged", int'(ctrl_rdata), 16'h11E);
    repeat (30) @(negedge clk);
    check(err == 1'b1, "R6 err sticky", int'(err), 1);

    // unmasked bits dropped: 0xF4E1 & 0x31F = 0x001 -> src1, N=1
    push_cfg(1, 1);
    write_a(16'hF4E1);
    wait_ready_a();
    check(ctrl_rdata == 16'h0001, "R7 layout0 mask", int'(ctrl_rdata), 16'h1);
    repeat (30) @(negedge clk);
    check(pulse_checks > 20, "R2 pulses observed", pulse_checks, 21);

    // second instance: layout 1, no divide-by-3
    write_b(16'h0070);
    check(err_b == 1'b1, "R4 code7 invalid without option", int'(err_b), 1);
    check(ready_b == 1'b1, "R6 layout1 ready stays", int'(ready_b), 1);
    check(ctrl_rdata_b == 16'h0, "R6 layout1 rdata unchanged", int'(ctrl_rdata_b), 0);
    write_b(16'hFD20);
    check(ctrl_rdata_b == 16'h0120, "R7 layout1 mask", int'(ctrl_rdata_b), 16'h120);
    while (!ready_b) @(negedge clk);
    @(negedge clk);
    while (!mck_en_b) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!mck_en_b);
    check(gap == 8, "R3 layout1 prescaler at bit 4", gap, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule